// File: doc/BRIEF.md
# Opcode Fetch Bus Cycle Sequencer

This block drives the memory bus for one instruction-byte fetch of a small 8-bit processor core. A one-clock `start` pulse, taken while the block is idle, begins a machine cycle of four clock states, T1 to T4. Extra wait states may be added between T2 and T3. The first half of the cycle is a read. The address register is loaded from the program counter. The memory-request and read strobes open half a clock later, and the byte on the data bus is stored when T3 begins.

The second half is a refresh slot for dynamic memory. A 7-bit refresh counter appears on the low address bits, the upper bits are zero, and the refresh strobe is low. The memory-request strobe pulses once more while the read strobe stays high. A `done` pulse marks the end of the cycle, and the refresh counter then moves on by one.

Strobes change on both clock edges. The state register advances on rising edges, and the half-clock strobe timing comes from flops on the falling edge.

Top module: `fetch_cycle_seq`

## Requirements
- R1: While `rst_n` is low, `m1_n`, `mreq_n`, `rd_n` and `rfsh_n` are high, `done` is low, and `addr` and `opcode` are zero.
- R2: A `start` seen high at a rising edge while idle begins T1. From that edge `addr` equals the `pc` sampled at that edge, and `m1_n` is low. `m1_n` stays low until the rising edge that begins T3.
- R3: `mreq_n` and `rd_n` stay high during the first half of T1. Both go low at the falling edge inside T1 and return high at the rising edge that begins T3.
- R4: `wait_n` is sampled at the falling edge inside T2 and at the falling edge inside each wait state. Each low sample adds one more wait state, during which `m1_n`, `mreq_n` and `rd_n` stay low and `rfsh_n` stays high.
- R5: `opcode` takes `data_in` at the rising edge that begins T3 and holds that value otherwise; data at other times has no effect.
- R6: During T3 and T4, `rfsh_n` is low, `m1_n` and `rd_n` are high, and `addr` equals the refresh count in bits 6:0 with zeros above.
- R7: In the refresh half, `mreq_n` is low from the falling edge inside T3 to the falling edge inside T4, and `addr` holds steady throughout.
- R8: `done` is high for exactly the one clock that follows T4.
- R9: The refresh count starts at 0 after reset and rises by one per completed fetch, wrapping from 127 to 0.
- R10: A `start` pulse during a running cycle has no effect: no new cycle begins after `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; states advance on rising edges |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begins a fetch when the block is idle |
| pc | input | ADDR_W | Program counter for the fetch |
| data_in | input | DATA_W | Data bus from memory |
| wait_n | input | 1 | Active-low wait request |
| addr | output | ADDR_W | Address bus |
| m1_n | output | 1 | Active-low opcode-read marker |
| mreq_n | output | 1 | Active-low memory request |
| rd_n | output | 1 | Active-low read strobe |
| rfsh_n | output | 1 | Active-low refresh strobe |
| done | output | 1 | One-clock fetch-complete pulse |
| opcode | output | DATA_W | Latched opcode byte |

## Verification
The bench checks both halves of T1 separately.
- Raising the read strobes on the rising edge instead of half a clock later would show up as a low `mreq_n` in the first half.
- A counter that sampled the wait line once only, or miscounted wait states, would reach T3 early or late.

The data bus carries the complement of the expected byte until just before the capture edge and again right after it. A capture on any other edge therefore stores the wrong byte.

The two refresh half-states are checked separately, so a memory request that ends on the wrong edge is caught. Over 130 fetches the refresh count passes 127 and must wrap to 0. A `start` pulse sent in mid-cycle must not cause a second `m1_n` after `done`.

// File: rtl/fcs_pkg.sv
package fcs_pkg;
   typedef enum logic [2:0] {
      ST_IDLE = 3'd0,
      ST_T1   = 3'd1,
      ST_T2   = 3'd2,
      ST_TW   = 3'd3,
      ST_T3   = 3'd4,
      ST_T4   = 3'd5
   } fcs_state_e;

   function automatic logic in_read_half(input fcs_state_e s);
      return (s == ST_T1) || (s == ST_T2) || (s == ST_TW);
   endfunction

   function automatic logic in_refresh_half(input fcs_state_e s);
      return (s == ST_T3) || (s == ST_T4);
   endfunction
endpackage

// File: rtl/fcs_state_seq.sv
module fcs_state_seq
   import fcs_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       start,
   input  logic       wait_n,
   output fcs_state_e state,
   output logic       capture,
   output logic       advance
);
   fcs_state_e state_d;
   logic       wait_q;

   // wait line is sampled half a clock into T2 and into each wait state
   always_ff @(negedge clk or negedge rst_n) begin
      if (!rst_n)
         wait_q <= 1'b1;
      else if (state == ST_T2 || state == ST_TW)
         wait_q <= wait_n;
   end

   always_comb begin
      state_d = state;
      case (state)
         ST_IDLE: if (start) state_d = ST_T1;
         ST_T1:   state_d = ST_T2;
         ST_T2,
         ST_TW:   state_d = wait_q ? ST_T3 : ST_TW;
         ST_T3:   state_d = ST_T4;
         ST_T4:   state_d = ST_IDLE;
         default: state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         state <= ST_IDLE;
      else
         state <= state_d;
   end

   assign capture = (state == ST_T2 || state == ST_TW) && wait_q;
   assign advance = (state == ST_T4);

   a_r2_start_enters_t1: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_IDLE && start) |=> (state == ST_T1));
   a_r4_wait_stretches: assert property (@(posedge clk) disable iff (!rst_n)
      ((state == ST_T2 || state == ST_TW) && !wait_q) |=> (state == ST_TW));
   a_r10_busy_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
      (state != ST_IDLE) |=> (state != ST_T1));
endmodule

// File: rtl/fcs_strobe_gen.sv
module fcs_strobe_gen
   import fcs_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  fcs_state_e state,
   output logic       m1_n,
   output logic       mreq_n,
   output logic       rd_n,
   output logic       rfsh_n
);
   logic rd_arm_q;
   logic rf_arm_q;
   logic rd_act;

   // falling-edge flops give the half-clock offsets of the strobes
   always_ff @(negedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_arm_q <= 1'b0;
         rf_arm_q <= 1'b0;
      end else begin
         rd_arm_q <= in_read_half(state);
         rf_arm_q <= (state == ST_T3);
      end
   end

   // read strobes close on the rising edge that leaves the read half
   assign rd_act = rd_arm_q && in_read_half(state);
   assign rd_n   = ~rd_act;
   assign mreq_n = ~(rd_act || rf_arm_q);
   assign m1_n   = ~in_read_half(state);
   assign rfsh_n = ~in_refresh_half(state);

   a_r3_read_within_request: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_n |-> !mreq_n);
   a_r6_no_read_in_refresh: assert property (@(posedge clk) disable iff (!rst_n)
      !rfsh_n |-> rd_n);
   a_r6_m1_excludes_refresh: assert property (@(posedge clk) disable iff (!rst_n)
      !(!m1_n && !rfsh_n));
endmodule

// File: rtl/fcs_refresh_ctr.sv
module fcs_refresh_ctr #(
   parameter int RFSH_W = 7
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              advance,
   output logic [RFSH_W-1:0] count
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         count <= '0;
      else if (advance)
         count <= count + 1'b1;
   end

   a_r9_count_step: assert property (@(posedge clk) disable iff (!rst_n)
      advance |=> (count == $past(count) + 1'b1));
   a_r9_count_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !advance |=> $stable(count));
endmodule

// File: rtl/fetch_cycle_seq.sv
module fetch_cycle_seq
   import fcs_pkg::*;
#(
   parameter int ADDR_W = 16,
   parameter int DATA_W = 8,
   parameter int RFSH_W = 7
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [ADDR_W-1:0] pc,
   input  logic [DATA_W-1:0] data_in,
   input  logic              wait_n,
   output logic [ADDR_W-1:0] addr,
   output logic              m1_n,
   output logic              mreq_n,
   output logic              rd_n,
   output logic              rfsh_n,
   output logic              done,
   output logic [DATA_W-1:0] opcode
);
   localparam int HI_W = ADDR_W - RFSH_W;

   if (RFSH_W < 1 || RFSH_W > ADDR_W) begin : g_bad_rfsh
      $error("RFSH_W must lie in 1..ADDR_W");
   end
   if (DATA_W < 1) begin : g_bad_data
      $error("DATA_W must be positive");
   end

   fcs_state_e        state;
   logic              capture;
   logic              advance;
   logic [RFSH_W-1:0] rf_count;
   logic [ADDR_W-1:0] rf_addr;
   logic [ADDR_W-1:0] pc_q;

   fcs_state_seq u_seq (
      .clk     (clk),
      .rst_n   (rst_n),
      .start   (start),
      .wait_n  (wait_n),
      .state   (state),
      .capture (capture),
      .advance (advance)
   );

   fcs_strobe_gen u_strobe (
      .clk    (clk),
      .rst_n  (rst_n),
      .state  (state),
      .m1_n   (m1_n),
      .mreq_n (mreq_n),
      .rd_n   (rd_n),
      .rfsh_n (rfsh_n)
   );

   fcs_refresh_ctr #(.RFSH_W(RFSH_W)) u_rfsh (
      .clk     (clk),
      .rst_n   (rst_n),
      .advance (advance),
      .count   (rf_count)
   );

   if (HI_W > 0) begin : g_pad
      assign rf_addr = {{HI_W{1'b0}}, rf_count};
   end else begin : g_full
      assign rf_addr = rf_count;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pc_q   <= '0;
         opcode <= '0;
         done   <= 1'b0;
      end else begin
         if (state == ST_IDLE && start)
            pc_q <= pc;
         if (capture)
            opcode <= data_in;
         done <= advance;
      end
   end

   always_comb begin
      if (in_read_half(state))
         addr = pc_q;
      else if (in_refresh_half(state))
         addr = rf_addr;
      else
         addr = '0;
   end

   a_r7_refresh_addr_stable: assert property (@(posedge clk) disable iff (!rst_n)
      (!rfsh_n && $past(!rfsh_n)) |-> $stable(addr));
   a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   a_r5_opcode_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (m1_n && rfsh_n) |=> $stable(opcode));
endmodule

// File: tb/fetch_cycle_seq_tb.sv
module fetch_cycle_seq_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [15:0] pc = '0;
   logic [7:0]  data_in = '0;
   logic        wait_n = 1'b1;
   logic [15:0] addr;
   logic        m1_n, mreq_n, rd_n, rfsh_n, done;
   logic [7:0]  opcode;

   int          nchk = 0;
   int          nfail = 0;
   logic [6:0]  exp_r = '0;

   always #2 clk = ~clk;

   fetch_cycle_seq u_dut (
      .clk(clk), .rst_n(rst_n), .start(start), .pc(pc), .data_in(data_in),
      .wait_n(wait_n), .addr(addr), .m1_n(m1_n), .mreq_n(mreq_n), .rd_n(rd_n),
      .rfsh_n(rfsh_n), .done(done), .opcode(opcode)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      nchk++;
      if (act !== exp) begin
         nfail++;
         $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
      end
   endtask

   task automatic test_reset();
      rst_n = 1'b0;
      repeat (3) @(posedge clk);
      #1;
      chk("R1 m1_n", m1_n, 1);
      chk("R1 mreq_n", mreq_n, 1);
      chk("R1 rd_n", rd_n, 1);
      chk("R1 rfsh_n", rfsh_n, 1);
      chk("R1 done", done, 0);
      chk("R1 addr", addr, 0);
      chk("R1 opcode", opcode, 0);
      rst_n = 1'b1;
      exp_r = '0;
   endtask

   task automatic run_fetch(input logic [15:0] p, input logic [7:0] d, input int nw, input bit poke);
      logic [7:0] old;
      old = opcode;
      @(posedge clk); #1;
      start = 1'b1; pc = p; data_in = ~d; wait_n = 1'b1;
      @(posedge clk); #1;                       // T1, high phase
      start = 1'b0; pc = ~p;
      chk("R2 addr=pc", addr, p);
      chk("R2 m1_n", m1_n, 0);
      chk("R3 mreq_n early", mreq_n, 1);
      chk("R3 rd_n early", rd_n, 1);
      @(negedge clk); #1;                       // T1, low phase
      chk("R3 mreq_n", mreq_n, 0);
      chk("R3 rd_n", rd_n, 0);
      chk("R2 addr held", addr, p);
      @(posedge clk); #1;                       // T2
      wait_n = (nw > 0) ? 1'b0 : 1'b1;
      if (nw == 0) data_in = d;
      if (poke) start = 1'b1;
      chk("R5 opcode not yet", opcode, old);
      chk("R3 mreq_n T2", mreq_n, 0);
      for (int k = 0; k < nw; k++) begin
         @(posedge clk); #1;                    // wait state
         start = 1'b0;
         chk("R4 m1_n in wait", m1_n, 0);
         chk("R4 mreq_n in wait", mreq_n, 0);
         chk("R4 rd_n in wait", rd_n, 0);
         chk("R4 rfsh_n in wait", rfsh_n, 1);
         chk("R5 opcode in wait", opcode, old);
         wait_n = (k + 1 < nw) ? 1'b0 : 1'b1;
         if (k == nw - 1) data_in = d;
      end
      @(posedge clk); #1;                       // T3
      start = 1'b0; data_in = ~d;
      chk("R5 opcode", opcode, d);
      chk("R3 rd_n off", rd_n, 1);
      chk("R3 mreq_n off", mreq_n, 1);
      chk("R6 rfsh_n", rfsh_n, 0);
      chk("R6 m1_n", m1_n, 1);
      chk("R6 R9 refresh addr", addr, {9'b0, exp_r});
      @(negedge clk); #1;
      chk("R7 mreq_n T3 low", mreq_n, 0);
      chk("R6 rd_n", rd_n, 1);
      @(posedge clk); #1;                       // T4
      chk("R7 mreq_n T4 high phase", mreq_n, 0);
      chk("R6 rfsh_n T4", rfsh_n, 0);
      chk("R8 done early", done, 0);
      @(negedge clk); #1;
      chk("R7 mreq_n end", mreq_n, 1);
      chk("R7 addr stable", addr, {9'b0, exp_r});
      @(posedge clk); #1;                       // clock after T4
      chk("R8 done", done, 1);
      chk("R6 rfsh_n off", rfsh_n, 1);
      chk("R5 opcode held", opcode, d);
      exp_r = exp_r + 7'd1;
      @(posedge clk); #1;
      chk("R8 done single", done, 0);
      if (poke) begin
         chk("R10 no restart", m1_n, 1);
         @(posedge clk); #1;
         chk("R10 still idle", m1_n, 1);
      end
   endtask

   task automatic test_basic();
      run_fetch(16'h1234, 8'hA5, 0, 1'b0);
      run_fetch(16'hFFFF, 8'h3C, 0, 1'b0);
   endtask

   task automatic test_waits();
      run_fetch(16'h8001, 8'h5A, 1, 1'b0);
      run_fetch(16'h0F0F, 8'hC3, 3, 1'b0);
   endtask

   task automatic test_busy_start();
      run_fetch(16'h4242, 8'h99, 2, 1'b1);
   endtask

   task automatic test_wrap();
      for (int i = 0; i < 130; i++)
         run_fetch(16'(i * 37), 8'(i * 11), i % 2, 1'b0);
      chk("R9 count wrapped", {25'b0, exp_r}, 32'd7);
   endtask

   initial begin
      #100000;
      nfail++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
   end

   initial begin
      test_reset();
      test_basic();
      test_waits();
      test_busy_start();
      test_wrap();
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
   end
endmodule